// File: doc/BRIEF.md
# Multicycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor. It runs one instruction over several clock cycles. One word-addressed memory array holds both the program and its data. A single adder/logic unit does three jobs in different cycles: it advances the program counter, computes the branch destination and executes the operation. Between cycles, values are held in a few buffer registers. These are the instruction register, the loaded-word register, the two operand registers and the result register. A state machine in the control module drives these registers, the shared unit and the multiplexers through a packed bundle of strobes.

The supported set is register-to-register arithmetic and logic, word load, word store, branch-if-equal and an absolute jump. Each kind takes its own number of cycles. The block has no bus. Its only pins are the clock, the reset and a set of debug outputs. The debug outputs show the program counter, the start of each instruction, and every register-file or memory write at the moment it is committed. A bench fills the internal memory before it releases reset.

Top module: `mcp_core`

## Requirements
- R1: While reset is high and right after it is released, the program counter reads 0. The controller is in its instruction-start state (the fetch flag is 1), and neither write strobe is active. Reset applied in the middle of an instruction aborts that instruction.
- R2: Each instruction is taken from the memory word at the program counter, and the counter then advances by 4. The fields are: opcode in bits 31:26, first source in 25:21, second source/target in 20:16, destination in 15:11, function in 5:0, 16-bit immediate in 15:0 and 26-bit jump index in 25:0. A load (opcode 0x23) takes 5 cycles. It writes register [20:16] with the memory word at first-source value plus the sign-extended immediate.
- R3: A store (opcode 0x2B) takes 4 cycles. It writes the second-source register value to the memory word at first-source value plus the sign-extended immediate. Immediates with the top bit set are negative offsets.
- R4: A register operation (opcode 0x00) takes 4 cycles and writes register [15:11]. The function codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and 0x2A signed set-less-than (result 1 or 0).
- R5: Branch-if-equal (opcode 0x04) takes 3 cycles and writes no register. When both sources are equal, the counter becomes (address + 4) plus the sign-extended immediate shifted left by 2. A negative immediate branches backwards. Otherwise the counter becomes address + 4.
- R6: A jump (opcode 0x02) takes 3 cycles. The counter becomes bits 31:28 of (address + 4), followed by the 26-bit index, followed by two zero bits.
- R7: Register 0 always reads as zero, even after an instruction names it as destination.
- R8: An unlisted opcode returns to fetch after 2 cycles with no register or memory write, and the counter advances by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dbgFetch | output | 1 | High in the first cycle of every instruction |
| dbgPc | output | 32 | Current program counter |
| dbgRegWe | output | 1 | Register-file write committed at the next edge |
| dbgRegIdx | output | 5 | Register being written |
| dbgRegData | output | 32 | Value being written to the register |
| dbgMemWe | output | 1 | Memory write committed at the next edge |
| dbgMemAddr | output | 32 | Byte address presented to memory |
| dbgMemData | output | 32 | Word being stored |

## Verification
The bench measures the cycle count of every instruction kind. A controller that sent a store through the load's write-back state, or a jump through the branch state, would show up as an extra or missing cycle. Branches are run in taken, not-taken and backward forms. A design that dropped the sign extension or the two-bit shift, or that left out the equality gate on the conditional write, would land on the wrong address. A store followed by a load of the same word catches a memory write that reaches the wrong address or never reaches it. A write that names register 0 and is then read back through a store catches a zero register that can be overwritten. A reset in the middle of an instruction confirms that the counter and the state machine both return to their starting point.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_LDMEM, S_LDWB,
    S_STMEM, S_EXEC, S_RWB, S_BRANCH, S_JUMP
  } state_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_FUNCT} aluSel_e;

  // pcSel: 0 live unit result, 1 result register, 2 jump destination
  // aluBSel: 0 operand B, 1 constant 4, 2 immediate, 3 immediate << 2
  typedef struct packed {
    logic       pcWrUncond;
    logic       pcWrBranch;
    logic       irWe;
    logic       memWe;
    logic       addrFromAlu;
    logic       aluAFromReg;
    logic [1:0] aluBSel;
    aluSel_e    aluSel;
    logic [1:0] pcSel;
    logic       regWe;
    logic       regDstRd;
    logic       regFromMem;
  } strobes_t;
endpackage

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
  import mcp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic [5:0] opcode,
  output strobes_t st,
  output state_e   stateQ
);
  state_e stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= S_FETCH;
    else     stateQ <= stateD;
  end

  always_comb begin
    st     = '0;
    stateD = S_FETCH;
    unique case (stateQ)
      S_FETCH: begin
        st.irWe       = 1'b1;
        st.aluBSel    = 2'd1;
        st.pcWrUncond = 1'b1;
        stateD        = S_DECODE;
      end
      S_DECODE: begin
        st.aluBSel = 2'd3;
        case (opcode)
          OP_LOAD, OP_STORE: stateD = S_ADDR;
          OP_REG:            stateD = S_EXEC;
          OP_BEQ:            stateD = S_BRANCH;
          OP_JUMP:           stateD = S_JUMP;
          default:           stateD = S_FETCH;
        endcase
      end
      S_ADDR: begin
        st.aluAFromReg = 1'b1;
        st.aluBSel     = 2'd2;
        stateD         = (opcode == OP_LOAD) ? S_LDMEM : S_STMEM;
      end
      S_LDMEM: begin
        st.addrFromAlu = 1'b1;
        stateD         = S_LDWB;
      end
      S_LDWB: begin
        st.regWe      = 1'b1;
        st.regFromMem = 1'b1;
      end
      S_STMEM: begin
        st.addrFromAlu = 1'b1;
        st.memWe       = 1'b1;
      end
      S_EXEC: begin
        st.aluAFromReg = 1'b1;
        st.aluSel      = ALU_FUNCT;
        stateD         = S_RWB;
      end
      S_RWB: begin
        st.regWe    = 1'b1;
        st.regDstRd = 1'b1;
      end
      S_BRANCH: begin
        st.aluAFromReg = 1'b1;
        st.aluSel      = ALU_SUB;
        st.pcSel       = 2'd1;
        st.pcWrBranch  = 1'b1;
      end
      S_JUMP: begin
        st.pcSel      = 2'd2;
        st.pcWrUncond = 1'b1;
      end
      default: stateD = S_FETCH;
    endcase
  end

  assert_decode_after_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    stateQ == S_FETCH |=> stateQ == S_DECODE);
  assert_one_commit_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.regWe, st.memWe, st.pcWrUncond | st.pcWrBranch}));
  assert_store_returns_R3: assert property (@(posedge clk) disable iff (rst)
    st.memWe |=> stateQ == S_FETCH);
endmodule

// File: rtl/mcp_datapath.sv
module mcp_datapath
  import mcp_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter int NREGS     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_t         st,
  output logic [5:0]       opcode,
  output logic [XLEN-1:0]  dbgPc,
  output logic             dbgRegWe,
  output logic [4:0]       dbgRegIdx,
  output logic [XLEN-1:0]  dbgRegData,
  output logic             dbgMemWe,
  output logic [XLEN-1:0]  dbgMemAddr,
  output logic [XLEN-1:0]  dbgMemData
);
  localparam int AW = $clog2(MEM_WORDS);

  logic [XLEN-1:0] mem  [MEM_WORDS];
  logic [XLEN-1:0] regs [NREGS];
  logic [XLEN-1:0] pcQ, irQ, mdrQ, aQ, bQ, aluOutQ;

  logic [4:0]  rsIdx, rtIdx, rdIdx, wrIdx;
  logic [5:0]  funct;
  logic [XLEN-1:0] memAddr, memRd, rdA, rdB, immExt, immSh, jumpTgt;
  logic [XLEN-1:0] aluA, aluB, aluRes, pcNext, wrData;
  logic [AW-1:0]   memIdx;
  logic zero, pcWe;

  assign opcode = irQ[31:26];
  assign rsIdx  = irQ[25:21];
  assign rtIdx  = irQ[20:16];
  assign rdIdx  = irQ[15:11];
  assign funct  = irQ[5:0];
  assign immExt = {{(XLEN-16){irQ[15]}}, irQ[15:0]};
  assign immSh  = {immExt[XLEN-3:0], 2'b00};
  assign jumpTgt = {pcQ[31:28], irQ[25:0], 2'b00};

  assign memAddr = st.addrFromAlu ? aluOutQ : pcQ;
  assign memIdx  = memAddr[AW+1:2];
  assign memRd   = mem[memIdx];

  assign rdA = (rsIdx == 5'd0) ? '0 : regs[rsIdx];
  assign rdB = (rtIdx == 5'd0) ? '0 : regs[rtIdx];

  assign aluA = st.aluAFromReg ? aQ : pcQ;
  always_comb begin
    unique case (st.aluBSel)
      2'd0: aluB = bQ;
      2'd1: aluB = 32'd4;
      2'd2: aluB = immExt;
      default: aluB = immSh;
    endcase
  end

  always_comb begin
    aluRes = aluA + aluB;
    if (st.aluSel == ALU_SUB) aluRes = aluA - aluB;
    else if (st.aluSel == ALU_FUNCT) begin
      case (funct)
        FN_SUB: aluRes = aluA - aluB;
        FN_AND: aluRes = aluA & aluB;
        FN_OR:  aluRes = aluA | aluB;
        FN_SLT: aluRes = ($signed(aluA) < $signed(aluB)) ? 32'd1 : 32'd0;
        default: aluRes = aluA + aluB;
      endcase
    end
  end
  assign zero = (aluRes == '0);

  always_comb begin
    unique case (st.pcSel)
      2'd1: pcNext = aluOutQ;
      2'd2: pcNext = jumpTgt;
      default: pcNext = aluRes;
    endcase
  end
  assign pcWe = (zero & st.pcWrBranch) | st.pcWrUncond;

  assign wrIdx  = st.regDstRd ? rdIdx : rtIdx;
  assign wrData = st.regFromMem ? mdrQ : aluOutQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ <= '0; irQ <= '0; mdrQ <= '0; aQ <= '0; bQ <= '0; aluOutQ <= '0;
    end else begin
      if (pcWe)    pcQ <= pcNext;
      if (st.irWe) irQ <= memRd;
      mdrQ    <= memRd;
      aQ      <= rdA;
      bQ      <= rdB;
      aluOutQ <= aluRes;
    end
  end

  always_ff @(posedge clk) begin
    if (st.memWe) mem[memIdx] <= bQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (st.regWe && wrIdx != 5'd0) begin
      regs[wrIdx] <= wrData;
    end
  end

  assign dbgPc      = pcQ;
  assign dbgRegWe   = st.regWe;
  assign dbgRegIdx  = wrIdx;
  assign dbgRegData = wrData;
  assign dbgMemWe   = st.memWe;
  assign dbgMemAddr = memAddr;
  assign dbgMemData = bQ;

  assert_fetch_advance_R2: assert property (@(posedge clk) disable iff (rst)
    st.irWe |=> pcQ == $past(pcQ) + 32'd4);
  assert_branch_taken_R5: assert property (@(posedge clk) disable iff (rst)
    (st.pcWrBranch && aQ == bQ) |=> pcQ == $past(aluOutQ));
  assert_branch_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (st.pcWrBranch && aQ != bQ) |=> $stable(pcQ));
  assert_zero_reg_R7: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);
endmodule

// File: rtl/mcp_core.sv
module mcp_core
  import mcp_pkg::*;
#(
  parameter int MEM_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst,
  output logic        dbgFetch,
  output logic [31:0] dbgPc,
  output logic        dbgRegWe,
  output logic [4:0]  dbgRegIdx,
  output logic [31:0] dbgRegData,
  output logic        dbgMemWe,
  output logic [31:0] dbgMemAddr,
  output logic [31:0] dbgMemData
);
  strobes_t   st;
  state_e     stateQ;
  logic [5:0] opcode;

  mcp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .st(st), .stateQ(stateQ)
  );

  mcp_datapath #(.MEM_WORDS(MEM_WORDS)) u_dp (
    .clk(clk), .rst(rst), .st(st), .opcode(opcode),
    .dbgPc(dbgPc), .dbgRegWe(dbgRegWe), .dbgRegIdx(dbgRegIdx),
    .dbgRegData(dbgRegData), .dbgMemWe(dbgMemWe),
    .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData)
  );

  assign dbgFetch = (stateQ == S_FETCH);
endmodule

// File: tb/mcp_core_bench.sv
`timescale 1ns/1ps
module mcp_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dbgFetch, dbgRegWe, dbgMemWe;
  logic [31:0] dbgPc, dbgRegData, dbgMemAddr, dbgMemData;
  logic [4:0]  dbgRegIdx;
  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  mcp_core u_mcp_core (
    .clk(clk), .rst(rst), .dbgFetch(dbgFetch), .dbgPc(dbgPc),
    .dbgRegWe(dbgRegWe), .dbgRegIdx(dbgRegIdx), .dbgRegData(dbgRegData),
    .dbgMemWe(dbgMemWe), .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData)
  );

  // kind: 0 no write, 1 register write (addr = index), 2 memory write
  typedef struct packed {
    logic [31:0] pc;
    logic [3:0]  cyc;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] nextPc;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{32'h00, 4'd5, 2'd1, 32'd1,   32'd7,  32'h04}, // R2 load
    '{32'h04, 4'd5, 2'd1, 32'd2,   32'd5,  32'h08}, // R2 load
    '{32'h08, 4'd4, 2'd1, 32'd3,   32'd12, 32'h0C}, // R4 add
    '{32'h0C, 4'd4, 2'd1, 32'd4,   32'd2,  32'h10}, // R4 sub
    '{32'h10, 4'd4, 2'd1, 32'd5,   32'd5,  32'h14}, // R4 and
    '{32'h14, 4'd4, 2'd1, 32'd6,   32'd7,  32'h18}, // R4 or
    '{32'h18, 4'd4, 2'd1, 32'd7,   32'd1,  32'h1C}, // R4 slt true
    '{32'h1C, 4'd4, 2'd1, 32'd8,   32'd0,  32'h20}, // R4 slt false
    '{32'h20, 4'd4, 2'd2, 32'h108, 32'd12, 32'h24}, // R3 store
    '{32'h24, 4'd5, 2'd1, 32'd9,   32'd12, 32'h28}, // R2 load after store
    '{32'h28, 4'd3, 2'd0, 32'd0,   32'd0,  32'h34}, // R5 taken forward
    '{32'h34, 4'd3, 2'd0, 32'd0,   32'd0,  32'h38}, // R5 not taken
    '{32'h38, 4'd4, 2'd1, 32'd0,   32'd14, 32'h3C}, // R7 write to r0
    '{32'h3C, 4'd4, 2'd2, 32'h10C, 32'd0,  32'h40}, // R7 r0 reads 0
    '{32'h40, 4'd3, 2'd0, 32'd0,   32'd0,  32'h50}, // R6 jump
    '{32'h50, 4'd3, 2'd0, 32'd0,   32'd0,  32'h48}, // R5 backward
    '{32'h48, 4'd3, 2'd0, 32'd0,   32'd0,  32'h58}, // R6 jump
    '{32'h58, 4'd4, 2'd2, 32'h04,  32'd7,  32'h5C}, // R3 negative offset
    '{32'h5C, 4'd5, 2'd1, 32'd13,  32'd7,  32'h60}, // R2 negative offset
    '{32'h60, 4'd2, 2'd0, 32'd0,   32'd0,  32'h64}, // R8 unknown opcode
    '{32'h64, 4'd3, 2'd0, 32'd0,   32'd0,  32'h64}, // R5 self loop
    '{32'h64, 4'd3, 2'd0, 32'd0,   32'd0,  32'h64}  // R5 self loop again
  };

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] encJ(logic [25:0] idx);
    return {6'h02, idx};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runInstr(input vec_t v, input string req);
    int cyc = 0;
    logic [1:0] kind = 2'd0;
    logic [31:0] addr = '0, data = '0;
    check(dbgPc == v.pc, req, "start pc", dbgPc, v.pc);
    do begin
      @(negedge clk);
      cyc++;
      if (dbgRegWe) begin kind = 2'd1; addr = {27'd0, dbgRegIdx}; data = dbgRegData; end
      if (dbgMemWe) begin kind = 2'd2; addr = dbgMemAddr; data = dbgMemData; end
    end while (!dbgFetch && cyc < 12);
    check(cyc == int'(v.cyc), req, "cycles", cyc, v.cyc);
    check(kind == v.kind, req, "write kind", kind, v.kind);
    if (v.kind != 2'd0) begin
      check(addr == v.addr, req, "write target", addr, v.addr);
      check(data == v.data, req, "write data", data, v.data);
    end
    check(dbgPc == v.nextPc, req, "next pc", dbgPc, v.nextPc);
  endtask

  initial begin
    u_mcp_core.u_dp.mem[0]  <= encI(6'h23, 0, 1, 16'h0100);
    u_mcp_core.u_dp.mem[1]  <= encI(6'h23, 0, 2, 16'h0104);
    u_mcp_core.u_dp.mem[2]  <= encR(1, 2, 3, 6'h20);
    u_mcp_core.u_dp.mem[3]  <= encR(1, 2, 4, 6'h22);
    u_mcp_core.u_dp.mem[4]  <= encR(1, 2, 5, 6'h24);
    u_mcp_core.u_dp.mem[5]  <= encR(1, 2, 6, 6'h25);
    u_mcp_core.u_dp.mem[6]  <= encR(2, 1, 7, 6'h2A);
    u_mcp_core.u_dp.mem[7]  <= encR(1, 2, 8, 6'h2A);
    u_mcp_core.u_dp.mem[8]  <= encI(6'h2B, 0, 3, 16'h0108);
    u_mcp_core.u_dp.mem[9]  <= encI(6'h23, 0, 9, 16'h0108);
    u_mcp_core.u_dp.mem[10] <= encI(6'h04, 1, 6, 16'h0002);
    u_mcp_core.u_dp.mem[11] <= encR(1, 1, 20, 6'h20);
    u_mcp_core.u_dp.mem[12] <= encR(1, 1, 20, 6'h20);
    u_mcp_core.u_dp.mem[13] <= encI(6'h04, 1, 2, 16'h0005);
    u_mcp_core.u_dp.mem[14] <= encR(1, 1, 0, 6'h20);
    u_mcp_core.u_dp.mem[15] <= encI(6'h2B, 0, 0, 16'h010C);
    u_mcp_core.u_dp.mem[16] <= encJ(26'h14);
    u_mcp_core.u_dp.mem[17] <= encR(1, 1, 20, 6'h20);
    u_mcp_core.u_dp.mem[18] <= encJ(26'h16);
    u_mcp_core.u_dp.mem[19] <= encR(1, 1, 20, 6'h20);
    u_mcp_core.u_dp.mem[20] <= encI(6'h04, 0, 0, 16'hFFFD);
    u_mcp_core.u_dp.mem[21] <= encR(1, 1, 20, 6'h20);
    u_mcp_core.u_dp.mem[22] <= encI(6'h2B, 3, 1, 16'hFFF8);
    u_mcp_core.u_dp.mem[23] <= encI(6'h23, 3, 13, 16'hFFF8);
    u_mcp_core.u_dp.mem[24] <= 32'hFC000000;
    u_mcp_core.u_dp.mem[25] <= encI(6'h04, 0, 0, 16'hFFFF);
    u_mcp_core.u_dp.mem[64] <= 32'd7;
    u_mcp_core.u_dp.mem[65] <= 32'd5;

    repeat (2) @(negedge clk);
    // R1 reset state
    check(dbgFetch == 1'b1, "R1", "fetch flag in reset", dbgFetch, 1);
    check(dbgPc == 32'd0, "R1", "pc in reset", dbgPc, 0);
    check(!dbgRegWe && !dbgMemWe, "R1", "write strobes in reset",
          {dbgRegWe, dbgMemWe}, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) runInstr(VEC[i], "R2-R8 table");

    // R1 reset in the middle of a load
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(dbgFetch == 1'b1, "R1", "fetch flag after mid reset", dbgFetch, 1);
    check(dbgPc == 32'd0, "R1", "pc after mid reset", dbgPc, 0);
    check(!dbgRegWe && !dbgMemWe, "R1", "no write after mid reset",
          {dbgRegWe, dbgMemWe}, 0);
    rst = 1'b0;
    runInstr(VEC[0], "R1 restart load");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule